// File: doc/BRIEF.md
# Bang-Bang PLL Lock Sequencer with Gain Stepping

This block drives the locking process of an all-digital bang-bang PLL. After a start request it moves the loop through three stages. The first is coarse frequency acquisition, with only the proportional path active at the largest gain. The second is fine acquisition, with the proportional path at the smallest gain. The third is phase tracking, with the integral path enabled. The block stops once tracking has worked through its gain schedule. Each acquisition stage lasts a programmed number of reference cycles, counted by an internal timer.

At each stage hand-over the sequencer emits three single-cycle strobes, in this order: capture the filter's control code, clear the phase detector, and preload the captured code into the integral register. During tracking the sequencer waits for a rising edge on the lock flag, and after that for a rising edge on the gain-change flag. It then issues a one-cycle gain-load pulse, and the current alpha and beta values are each shifted right by a per-step amount taken from the programmable shift inputs. Five alpha/beta pairs exist, so four gain loads occur before the block reports done. The loop-filter arithmetic is outside this block.

Top module: `adpll_lock_seq`

## Requirements
- R1: While `rst` is high and after its release, all strobes (`cap_stb`, `pd_clr`, `int_load`, `gain_ld`), `int_en` and `done` are 0, `alpha` and `beta` are 0, and `acq_shift` equals COARSE_SHIFT.
- R2: A `start` pulse accepted while idle loads `alpha_init` and `beta_init` into `alpha` and `beta` and begins coarse acquisition. Coarse acquisition lasts `coarse_len` cycles (a value of 0 counts as 1), and `acq_shift` equals COARSE_SHIFT during it. `start` has no effect outside idle.
- R3: Coarse acquisition ends with `cap_stb`, `pd_clr` and `int_load` high for one cycle each, in three consecutive cycles in that order, and with at most one strobe high in any cycle. After these strobes `acq_shift` equals FINE_SHIFT.
- R4: Fine acquisition lasts `fine_len` cycles (0 counts as 1). It is followed by the same three-strobe hand-over. `int_en` rises in the cycle after `int_load` and stays high until reset.
- R5: Lock and gain-change edges have no effect outside tracking. In tracking, a gain-change edge that arrives before a lock edge has no effect.
- R6: A gain-change rising edge that arrives after a lock edge in tracking makes `gain_ld` high for exactly one cycle, starting one cycle after the edge is sampled.
- R7: At gain load number k (k = 0 to 3), `alpha` is shifted right by `alpha_shamt[3k+2:3k]` and `beta` by `beta_shamt[3k+2:3k]`. The new values appear one cycle after `gain_ld`, and `gain_step` then counts k+1.
- R8: After the fourth gain load, `done` rises in the following cycle and stays high. No further `gain_ld` occurs until reset.
- R9: A flag held high produces only one event. Starting a new gain step requires the lock flag to fall and rise again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begins the locking sequence when idle |
| coarse_len | input | CNTW | Coarse acquisition length in cycles |
| fine_len | input | CNTW | Fine acquisition length in cycles |
| lock_in | input | 1 | Lock flag from the lock monitor |
| gchg_in | input | 1 | Gain-change flag |
| alpha_init | input | GW | Initial integral gain |
| beta_init | input | GW | Initial proportional gain |
| alpha_shamt | input | (NPAIR-1)*SHW | Per-step alpha shift amounts, step k at bits [k*SHW +: SHW] |
| beta_shamt | input | (NPAIR-1)*SHW | Per-step beta shift amounts, same layout |
| cap_stb | output | 1 | Capture control code |
| pd_clr | output | 1 | Phase detector clear |
| int_load | output | 1 | Preload integral register |
| gain_ld | output | 1 | Gain-load pulse |
| int_en | output | 1 | Integral path enable (tracking mode) |
| acq_shift | output | SHW | Proportional shift used during acquisition |
| alpha | output | GW | Current integral gain |
| beta | output | GW | Current proportional gain |
| gain_step | output | IW | Number of gain loads done |
| done | output | 1 | Sequence finished |

## Verification
The bench builds the block with GW=16, NPAIR=5, SHW=3, CNTW=12, COARSE_SHIFT=0 and FINE_SHIFT=3. With these values all four gain steps, each with its own shift amount, fit into a short run. One run uses stage lengths of 20 and 9 cycles. A second run uses the minimum lengths of 1 and 2 together with zero shift amounts, which checks the timer boundary and the case where a gain load leaves the gains unchanged. The 3-bit shift fields let the alpha and beta sequences be predicted exactly across all five pairs.

// File: rtl/adpll_seq_pkg.sv
package adpll_seq_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_COARSE,
        ST_CAP1,
        ST_CLR1,
        ST_LOAD1,
        ST_FINE,
        ST_CAP2,
        ST_CLR2,
        ST_LOAD2,
        ST_TRACK,
        ST_WAIT_GCHG,
        ST_GAIN_LD,
        ST_DONE
    } seq_state_e;

    typedef struct packed {
        logic cap;
        logic clr;
        logic load;
        logic gld;
        logic integ;
        logic fine;
        logic fin;
    } seq_out_t;

    function automatic seq_out_t decode_state(seq_state_e s);
        seq_out_t o;
        o       = '0;
        o.cap   = (s == ST_CAP1)  || (s == ST_CAP2);
        o.clr   = (s == ST_CLR1)  || (s == ST_CLR2);
        o.load  = (s == ST_LOAD1) || (s == ST_LOAD2);
        o.gld   = (s == ST_GAIN_LD);
        o.integ = (s == ST_TRACK) || (s == ST_WAIT_GCHG) ||
                  (s == ST_GAIN_LD) || (s == ST_DONE);
        o.fine  = !((s == ST_IDLE) || (s == ST_COARSE) || (s == ST_CAP1) ||
                    (s == ST_CLR1) || (s == ST_LOAD1));
        o.fin   = (s == ST_DONE);
        return o;
    endfunction

endpackage

// File: rtl/adpll_edge_bank.sv
module adpll_edge_bank #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] lvl,
    output logic [N-1:0] rise
);
    for (genvar i = 0; i < N; i++) begin : g_flag
        logic prev_d, prev_q;

        always_comb begin
            prev_d  = lvl[i];
            rise[i] = lvl[i] & ~prev_q;
        end

        always_ff @(posedge clk) begin
            if (rst) prev_q <= 1'b0;
            else     prev_q <= prev_d;
        end
    end
endmodule

// File: rtl/adpll_dwell_timer.sv
module adpll_dwell_timer #(
    parameter int CW = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic [CW-1:0] limit,
    output logic          expired
);
    logic [CW-1:0] cnt_d, cnt_q;
    logic [CW:0]   nxt;

    always_comb begin
        nxt     = {1'b0, cnt_q} + 1'b1;
        expired = run && (nxt >= {1'b0, limit});
        if (!run || expired)
            cnt_d = '0;
        else if (&cnt_q)
            cnt_d = cnt_q;
        else
            cnt_d = nxt[CW-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end
endmodule

// File: rtl/adpll_gain_bank.sv
module adpll_gain_bank #(
    parameter int GW    = 16,
    parameter int SHW   = 3,
    parameter int NPAIR = 5,
    localparam int NSTEP = NPAIR - 1,
    localparam int IW    = $clog2(NPAIR)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 init_ld,
    input  logic                 step,
    input  logic [GW-1:0]        a_init,
    input  logic [GW-1:0]        b_init,
    input  logic [NSTEP*SHW-1:0] a_sh,
    input  logic [NSTEP*SHW-1:0] b_sh,
    output logic [GW-1:0]        a_val,
    output logic [GW-1:0]        b_val,
    output logic [IW-1:0]        idx,
    output logic                 last
);
    typedef struct packed {
        logic [GW-1:0] a;
        logic [GW-1:0] b;
        logic [IW-1:0] k;
    } gain_reg_t;

    gain_reg_t r_d, r_q;
    logic [SHW-1:0] a_amt, b_amt;
    logic [SHW-1:0] a_tab [NSTEP];
    logic [SHW-1:0] b_tab [NSTEP];

    for (genvar s = 0; s < NSTEP; s++) begin : g_tab
        assign a_tab[s] = a_sh[s*SHW +: SHW];
        assign b_tab[s] = b_sh[s*SHW +: SHW];
    end

    always_comb begin
        a_amt = '0;
        b_amt = '0;
        for (int s = 0; s < NSTEP; s++) begin
            if (r_q.k == IW'(s)) begin
                a_amt = a_tab[s];
                b_amt = b_tab[s];
            end
        end
    end

    always_comb begin
        r_d = r_q;
        if (init_ld) begin
            r_d.a = a_init;
            r_d.b = b_init;
            r_d.k = '0;
        end else if (step && (r_q.k < IW'(NSTEP))) begin
            r_d.a = r_q.a >> a_amt;
            r_d.b = r_q.b >> b_amt;
            r_d.k = r_q.k + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) r_q <= '0;
        else     r_q <= r_d;
    end

    assign a_val = r_q.a;
    assign b_val = r_q.b;
    assign idx   = r_q.k;
    assign last  = (r_q.k == IW'(NSTEP - 1));
endmodule

// File: rtl/adpll_lock_seq.sv
module adpll_lock_seq
    import adpll_seq_pkg::*;
#(
    parameter int GW           = 16,
    parameter int SHW          = 3,
    parameter int NPAIR        = 5,
    parameter int CNTW         = 12,
    parameter int COARSE_SHIFT = 0,
    parameter int FINE_SHIFT   = 3,
    localparam int NSTEP = NPAIR - 1,
    localparam int IW    = $clog2(NPAIR)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic [CNTW-1:0]      coarse_len,
    input  logic [CNTW-1:0]      fine_len,
    input  logic                 lock_in,
    input  logic                 gchg_in,
    input  logic [GW-1:0]        alpha_init,
    input  logic [GW-1:0]        beta_init,
    input  logic [NSTEP*SHW-1:0] alpha_shamt,
    input  logic [NSTEP*SHW-1:0] beta_shamt,
    output logic                 cap_stb,
    output logic                 pd_clr,
    output logic                 int_load,
    output logic                 gain_ld,
    output logic                 int_en,
    output logic [SHW-1:0]       acq_shift,
    output logic [GW-1:0]        alpha,
    output logic [GW-1:0]        beta,
    output logic [IW-1:0]        gain_step,
    output logic                 done
);
    typedef struct packed {
        seq_state_e st;
    } seq_reg_t;

    seq_reg_t s_d, s_q;
    seq_out_t dec;

    logic [1:0]      ev_rise;
    logic            lock_ev, gchg_ev;
    logic            tmr_run, tmr_exp;
    logic [CNTW-1:0] tmr_lim;
    logic            gain_init, gain_last;

    adpll_edge_bank #(.N(2)) i_edges (
        .clk  (clk),
        .rst  (rst),
        .lvl  ({gchg_in, lock_in}),
        .rise (ev_rise)
    );
    assign lock_ev = ev_rise[0];
    assign gchg_ev = ev_rise[1];

    always_comb begin
        tmr_run = (s_q.st == ST_COARSE) || (s_q.st == ST_FINE);
        tmr_lim = (s_q.st == ST_FINE) ? fine_len : coarse_len;
    end

    adpll_dwell_timer #(.CW(CNTW)) i_timer (
        .clk     (clk),
        .rst     (rst),
        .run     (tmr_run),
        .limit   (tmr_lim),
        .expired (tmr_exp)
    );

    assign gain_init = (s_q.st == ST_IDLE) && start;

    adpll_gain_bank #(.GW(GW), .SHW(SHW), .NPAIR(NPAIR)) i_gains (
        .clk     (clk),
        .rst     (rst),
        .init_ld (gain_init),
        .step    (dec.gld),
        .a_init  (alpha_init),
        .b_init  (beta_init),
        .a_sh    (alpha_shamt),
        .b_sh    (beta_shamt),
        .a_val   (alpha),
        .b_val   (beta),
        .idx     (gain_step),
        .last    (gain_last)
    );

    always_comb begin
        s_d = s_q;
        unique case (s_q.st)
            ST_IDLE:      if (start)   s_d.st = ST_COARSE;
            ST_COARSE:    if (tmr_exp) s_d.st = ST_CAP1;
            ST_CAP1:      s_d.st = ST_CLR1;
            ST_CLR1:      s_d.st = ST_LOAD1;
            ST_LOAD1:     s_d.st = ST_FINE;
            ST_FINE:      if (tmr_exp) s_d.st = ST_CAP2;
            ST_CAP2:      s_d.st = ST_CLR2;
            ST_CLR2:      s_d.st = ST_LOAD2;
            ST_LOAD2:     s_d.st = ST_TRACK;
            ST_TRACK:     if (lock_ev) s_d.st = ST_WAIT_GCHG;
            ST_WAIT_GCHG: if (gchg_ev) s_d.st = ST_GAIN_LD;
            ST_GAIN_LD:   s_d.st = gain_last ? ST_DONE : ST_TRACK;
            ST_DONE:      s_d.st = ST_DONE;
            default:      s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) s_q.st <= ST_IDLE;
        else     s_q    <= s_d;
    end

    assign dec       = decode_state(s_q.st);
    assign cap_stb   = dec.cap;
    assign pd_clr    = dec.clr;
    assign int_load  = dec.load;
    assign gain_ld   = dec.gld;
    assign int_en    = dec.integ;
    assign done      = dec.fin;
    assign acq_shift = dec.fine ? SHW'(FINE_SHIFT) : SHW'(COARSE_SHIFT);
endmodule

// File: rtl/adpll_lock_seq_chk.sv
module adpll_lock_seq_chk #(
    parameter int GW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          cap_stb,
    input logic          pd_clr,
    input logic          int_load,
    input logic          gain_ld,
    input logic          int_en,
    input logic          done,
    input logic [GW-1:0] alpha,
    input logic [GW-1:0] beta
);
    // R3
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({cap_stb, pd_clr, int_load, gain_ld}));
    // R3
    clr_after_cap_chk: assert property (@(posedge clk) disable iff (rst)
        pd_clr |-> $past(cap_stb));
    // R3
    load_after_clr_chk: assert property (@(posedge clk) disable iff (rst)
        int_load |-> $past(pd_clr));
    // R4
    integ_after_load_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(int_en) |-> $past(int_load));
    // R4
    integ_hold_chk: assert property (@(posedge clk) disable iff (rst)
        int_en |=> int_en);
    // R6
    gain_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        gain_ld |=> !gain_ld);
    // R7
    gain_shrink_chk: assert property (@(posedge clk) disable iff (rst)
        gain_ld |=> (alpha <= $past(alpha)) && (beta <= $past(beta)));
    // R8
    done_hold_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> done && !gain_ld);
endmodule

bind adpll_lock_seq adpll_lock_seq_chk #(.GW(GW)) i_chk (
    .clk      (clk),
    .rst      (rst),
    .cap_stb  (cap_stb),
    .pd_clr   (pd_clr),
    .int_load (int_load),
    .gain_ld  (gain_ld),
    .int_en   (int_en),
    .done     (done),
    .alpha    (alpha),
    .beta     (beta)
);

// File: tb/test_adpll_lock_seq.sv
module test_adpll_lock_seq;
    localparam int GW = 16, SHW = 3, NPAIR = 5, CNTW = 12;
    localparam int CS = 0, FS = 3, NSTEP = NPAIR - 1, IW = $clog2(NPAIR);

    logic clk = 0, rst = 1, start = 0, lock_in = 0, gchg_in = 0;
    logic [CNTW-1:0] coarse_len = '0, fine_len = '0;
    logic [GW-1:0] alpha_init = '0, beta_init = '0;
    logic [NSTEP*SHW-1:0] alpha_shamt = '0, beta_shamt = '0;
    logic cap_stb, pd_clr, int_load, gain_ld, int_en, done;
    logic [SHW-1:0] acq_shift;
    logic [GW-1:0] alpha, beta;
    logic [IW-1:0] gain_step;

    always #2 clk = ~clk;

    adpll_lock_seq #(.GW(GW), .SHW(SHW), .NPAIR(NPAIR), .CNTW(CNTW),
                     .COARSE_SHIFT(CS), .FINE_SHIFT(FS)) i_adpll_lock_seq (
        .clk(clk), .rst(rst), .start(start), .coarse_len(coarse_len),
        .fine_len(fine_len), .lock_in(lock_in), .gchg_in(gchg_in),
        .alpha_init(alpha_init), .beta_init(beta_init),
        .alpha_shamt(alpha_shamt), .beta_shamt(beta_shamt),
        .cap_stb(cap_stb), .pd_clr(pd_clr), .int_load(int_load),
        .gain_ld(gain_ld), .int_en(int_en), .acq_shift(acq_shift),
        .alpha(alpha), .beta(beta), .gain_step(gain_step), .done(done));

    typedef struct { string name; int cyc; string req; } ev_t;
    ev_t exp_q[$];
    int n_cmp = 0, n_bad = 0, cyc = 0;
    logic prev_int = 0, prev_done = 0, finished = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    task automatic push(input string name, input int c, input string req);
        ev_t e;
        e.name = name; e.cyc = c; e.req = req;
        exp_q.push_back(e);
    endtask

    task automatic observe(input string name);
        ev_t e;
        if (exp_q.size() == 0) begin
            n_cmp++; n_bad++;
            $display("FAIL R5 unexpected %s: actual cycle %0d expected none", name, cyc);
        end else begin
            e = exp_q.pop_front();
            chk(e.name == name && e.cyc == cyc, e.req, {"event ", e.name, " got ", name},
                cyc, e.cyc);
        end
    endtask

    // monitor: pops the expected queue as strobes appear
    always @(negedge clk) begin
        if (!rst) begin
            if (cap_stb)  observe("CAP");
            if (pd_clr)   observe("CLR");
            if (int_load) observe("LOAD");
            if (gain_ld)  observe("GLD");
            if (int_en && !prev_int)  observe("INT");
            if (done && !prev_done)   observe("DONE");
        end
        prev_int  <= rst ? 1'b0 : int_en;
        prev_done <= rst ? 1'b0 : done;
    end

    task automatic wait_until(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    task automatic run_seq(input int L, input int F, input logic [GW-1:0] ai,
                           input logic [GW-1:0] bi, input logic [NSTEP*SHW-1:0] ash,
                           input logic [NSTEP*SHW-1:0] bsh);
        int c0, g, le, fe;
        logic [GW-1:0] ea, eb;
        @(negedge clk);
        rst = 1; start = 0; lock_in = 0; gchg_in = 0;
        coarse_len = CNTW'(L); fine_len = CNTW'(F);
        alpha_init = ai; beta_init = bi; alpha_shamt = ash; beta_shamt = bsh;
        repeat (3) @(negedge clk);
        // R1: outputs during reset
        chk({cap_stb, pd_clr, int_load, gain_ld, int_en, done} == 6'b0, "R1", "strobes in reset",
            {cap_stb, pd_clr, int_load, gain_ld, int_en, done}, 0);
        rst = 0;
        @(negedge clk);
        chk(alpha == 0 && beta == 0, "R1", "gains after reset", alpha, 0);
        chk(acq_shift == SHW'(CS), "R1", "shift after reset", acq_shift, CS);
        le = (L == 0) ? 1 : L;
        fe = (F == 0) ? 1 : F;
        c0 = cyc;
        push("CAP",  c0 + le + 1, "R3");
        push("CLR",  c0 + le + 2, "R3");
        push("LOAD", c0 + le + 3, "R3");
        push("CAP",  c0 + le + fe + 4, "R4");
        push("CLR",  c0 + le + fe + 5, "R4");
        push("LOAD", c0 + le + fe + 6, "R4");
        push("INT",  c0 + le + fe + 7, "R4");
        start = 1;
        @(negedge clk);
        start = 0;
        chk(alpha == ai && beta == bi, "R2", "initial gains loaded", alpha, ai);
        chk(acq_shift == SHW'(CS), "R2", "coarse shift", acq_shift, CS);
        // R5: flags during acquisition are ignored; R2: extra start ignored
        lock_in = 1; gchg_in = 1; start = 1;
        @(negedge clk);
        lock_in = 0; gchg_in = 0; start = 0;
        wait_until(c0 + le + 4);
        chk(acq_shift == SHW'(FS), "R3", "fine shift after hand-over", acq_shift, FS);
        lock_in = 1; @(negedge clk); gchg_in = 1; @(negedge clk);
        lock_in = 0; gchg_in = 0;
        wait_until(c0 + le + fe + 8);
        chk(int_en == 1'b1, "R4", "integral path on", int_en, 1);
        ea = ai; eb = bi;
        for (int k = 0; k < NSTEP; k++) begin
            if (lock_in) begin
                // R9: lock still high from last step, gchg alone must not step
                gchg_in = 1; @(negedge clk); gchg_in = 0;
                repeat (2) @(negedge clk);
                chk(gain_step == IW'(k), "R9", "held lock gives no step", gain_step, k);
                lock_in = 0; @(negedge clk);
            end
            // R5: gain-change before lock is ignored
            gchg_in = 1; @(negedge clk); gchg_in = 0; @(negedge clk);
            chk(gain_step == IW'(k), "R5", "gchg before lock", gain_step, k);
            lock_in = 1;
            repeat (2) @(negedge clk);
            g = cyc;
            push("GLD", g + 1, "R6");
            if (k == NSTEP - 1) push("DONE", g + 2, "R8");
            gchg_in = 1;
            @(negedge clk);
            gchg_in = 0;
            wait_until(g + 2);
            ea = ea >> ash[k*SHW +: SHW];
            eb = eb >> bsh[k*SHW +: SHW];
            chk(alpha == ea, "R7", "alpha after step", alpha, ea);
            chk(beta == eb, "R7", "beta after step", beta, eb);
            chk(gain_step == IW'(k + 1), "R7", "step count", gain_step, k + 1);
        end
        // R8: events after done are ignored
        lock_in = 0; @(negedge clk); lock_in = 1; @(negedge clk);
        gchg_in = 1; @(negedge clk); gchg_in = 0;
        repeat (4) @(negedge clk);
        chk(done == 1'b1 && int_en == 1'b1, "R8", "done held", done, 1);
        chk(gain_step == IW'(NSTEP), "R8", "four gain loads", gain_step, NSTEP);
        chk(exp_q.size() == 0, "R8", "pending events", exp_q.size(), 0);
        exp_q.delete();
    endtask

    initial begin
        run_seq(20, 9, 16'hF0A0, 16'h7C00, {3'd3, 3'd1, 3'd2, 3'd1}, {3'd1, 3'd2, 3'd2, 3'd3});
        run_seq(1, 2, 16'h8001, 16'h0FFF, '0, '0);
        run_seq(0, 0, 16'hFFFF, 16'hFFFF, {3'd7, 3'd0, 3'd4, 3'd2}, {3'd0, 3'd5, 3'd1, 3'd6});
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule